// File: doc/BRIEF.md
# Bus-Width Adapting Register Read Port

This block is the read side of a slave port. A microcontroller reads a bank of internal 32-bit registers through it over an external data bus that is either 32 or 16 bits wide. A static mode pin selects the width. The adapter splits the byte address into a register index and a byte offset. It fetches the addressed register, then moves the requested bytes onto the external data lanes for byte, halfword and word reads. In the 16-bit mode a word read is returned as two halfword beats on consecutive cycles, with the upper half first.

The data returned in the narrow mode depends only on the current address, size and mode. No state is left behind by earlier reads. A halfword at offset 2, or a byte at offset 2 or 3, is therefore correct even when it is the first read after reset or follows any other access. Out-of-range and misaligned reads return zero and raise a one-cycle flag. The register bank in the project is a model for testing: each register's value is computed from its index.

Top module: `regrd_adapter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rd_valid`, `rd_err`, `rd_misalign` and `rd_busy` are 0 and `rd_data` is 0.
- R2: Address bits 15:2 select the register index i, and bits 1:0 are the byte offset. The test bank returns a word whose bytes are, from bits 31:24 down to bits 7:0: i[7:0] xor 0x5A; 0x80 or i[13:8]; not i[7:0]; i[7:0] + 0x11. Offset 0 names bits 31:24 and offset 3 names bits 7:0.
- R3: `rd_size` encodes 0 = byte, 1 = halfword, 2 = word and 3 = reserved. With `wide_mode` = 1, an aligned word read returns the full register on bits 31:0.
- R4: With `wide_mode` = 1, a halfword or byte read places the selected lanes at their big-endian positions. Offset 0 or 2 selects bits 31:16 or 15:0 for a halfword, and offset n selects bits 31-8n down to 24-8n for a byte. All other lanes are 0.
- R5: With `wide_mode` = 0, a halfword read at offset 0 returns register bits 31:16 and at offset 2 returns bits 15:0. Both are placed on `rd_data[15:0]`, and bits 31:16 are 0.
- R6: With `wide_mode` = 0, a byte read places the addressed byte on bits 15:8 for offsets 0 and 2 and on bits 7:0 for offsets 1 and 3. All other bits are 0.
- R7: With `wide_mode` = 0, an aligned word read yields two valid beats on consecutive cycles: register bits 31:16 first, then bits 15:0, both on `rd_data[15:0]`. `rd_busy` is 1 during the first beat, and a strobe in that cycle is ignored.
- R8: In narrow mode, reads at offsets 2 and 3 return correct data as the first read after reset and directly after a read of any other register, offset or size.
- R9: A read at an address above 0xFBFF returns 0 with `rd_valid` = 1 and `rd_err` = 1 for exactly that one cycle.
- R10: A halfword read at an odd offset, a word read at a non-zero offset, or a reserved size returns 0 with `rd_valid` = 1 and `rd_misalign` = 1 for one cycle. `rd_err` takes precedence, so the two flags are never both 1.
- R11: Results appear with `rd_valid` = 1 in the cycle after the strobe. Strobes on consecutive cycles each get their own result, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | Bus width select: 1 = 32-bit, 0 = 16-bit (static) |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| rd_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| rd_addr | input | 16 | Byte address |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| rd_err | output | 1 | Address out of range, one cycle |
| rd_misalign | output | 1 | Misaligned or reserved-size access, one cycle |
| rd_busy | output | 1 | Second narrow word beat pending; strobes ignored |

## Verification
A stale pending-beat flag or a lane select left over from an earlier read would show at the ports one cycle after the next strobe. It would appear as a wrong value on `rd_data`, a spurious extra valid beat, or a strobe that is ignored without reason. The tests therefore place offset-2 and offset-3 reads directly after reads of other sizes and registers and right after reset. They also check every beat cycle by cycle, so that a corrupted value cannot go unnoticed for more than one cycle.

// File: rtl/regrd_pkg.sv
package regrd_pkg;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } rd_size_e;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic              mis;
        logic              pend;
        logic [DATA_W-1:0] data;
        logic [HALF_W-1:0] tail;
    } rd_state_t;
endpackage

// File: rtl/regrd_decode.sv
module regrd_decode
    import regrd_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] TOP_ADDR = 16'hFBFF,
    localparam int             IDX_W    = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  rd_size_e          size,
    output logic [IDX_W-1:0]  idx,
    output logic [1:0]        off,
    output logic              out_of_range,
    output logic              misaligned
);
    always_comb begin
        idx          = addr[ADDR_W-1:2];
        off          = addr[1:0];
        out_of_range = (addr > TOP_ADDR);
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = addr[0];
            SZ_WORD: misaligned = (addr[1:0] != 2'b00);
            default: misaligned = 1'b1;
        endcase
    end
endmodule

// File: rtl/regrd_bank.sv
module regrd_bank
    import regrd_pkg::*;
#(
    parameter int IDX_W = 14
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);
    logic [7:0] lo;
    logic [7:0] hi;

    always_comb begin
        lo   = idx[7:0];
        hi   = 8'(idx >> 8) | 8'h80;
        word = {lo ^ 8'h5A, hi, ~lo, lo + 8'h11};
    end
endmodule

// File: rtl/regrd_lanes.sv
module regrd_lanes
    import regrd_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [1:0]        off,
    input  rd_size_e          size,
    input  logic              wide,
    output logic [DATA_W-1:0] lane_data,
    output logic [HALF_W-1:0] lane_tail
);
    logic [7:0]        sel_byte;
    logic [HALF_W-1:0] sel_half;

    always_comb begin
        sel_byte  = word[8*(3-int'(off)) +: 8];
        sel_half  = off[1] ? word[HALF_W-1:0] : word[DATA_W-1:HALF_W];
        lane_data = '0;
        lane_tail = '0;
        unique case (size)
            SZ_BYTE: begin
                if (wide)        lane_data[8*(3-int'(off)) +: 8] = sel_byte;
                else if (off[0]) lane_data[7:0]  = sel_byte;
                else             lane_data[15:8] = sel_byte;
            end
            SZ_HALF: begin
                if (wide && !off[1]) lane_data[DATA_W-1:HALF_W] = sel_half;
                else                 lane_data[HALF_W-1:0]      = sel_half;
            end
            SZ_WORD: begin
                if (wide) begin
                    lane_data = word;
                end else begin
                    lane_data[HALF_W-1:0] = word[DATA_W-1:HALF_W];
                    lane_tail             = word[HALF_W-1:0];
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/regrd_adapter.sv
module regrd_adapter
    import regrd_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] TOP_ADDR = 16'hFBFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              rd_stb,
    input  logic [1:0]        rd_size,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              rd_err,
    output logic              rd_misalign,
    output logic              rd_busy
);
    localparam int IDX_W = ADDR_W - 2;

    rd_size_e          size_e;
    logic [IDX_W-1:0]  reg_idx;
    logic [1:0]        byte_off;
    logic              oor;
    logic              mis;
    logic [DATA_W-1:0] reg_word;
    logic [DATA_W-1:0] lane_data;
    logic [HALF_W-1:0] lane_tail;
    rd_state_t         st_d, st_q;

    assign size_e = rd_size_e'(rd_size);

    regrd_decode #(.ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR)) u_decode (
        .addr(rd_addr), .size(size_e), .idx(reg_idx), .off(byte_off),
        .out_of_range(oor), .misaligned(mis)
    );

    regrd_bank #(.IDX_W(IDX_W)) u_bank (
        .idx(reg_idx), .word(reg_word)
    );

    regrd_lanes u_lanes (
        .word(reg_word), .off(byte_off), .size(size_e), .wide(wide_mode),
        .lane_data(lane_data), .lane_tail(lane_tail)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.err   = 1'b0;
        st_d.mis   = 1'b0;
        st_d.data  = '0;
        if (st_q.pend) begin
            st_d.valid = 1'b1;
            st_d.pend  = 1'b0;
            st_d.data  = {{HALF_W{1'b0}}, st_q.tail};
        end else if (rd_stb) begin
            st_d.valid = 1'b1;
            if (oor) begin
                st_d.err = 1'b1;
            end else if (mis) begin
                st_d.mis = 1'b1;
            end else begin
                st_d.data = lane_data;
                st_d.pend = !wide_mode && (size_e == SZ_WORD);
                st_d.tail = lane_tail;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data     = st_q.data;
    assign rd_valid    = st_q.valid;
    assign rd_err      = st_q.err;
    assign rd_misalign = st_q.mis;
    assign rd_busy     = st_q.pend;

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_err && rd_misalign)); // R10
    AST_FLAG_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_err || rd_misalign) |-> (rd_valid && rd_data == '0)); // R9
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |=> !rd_err || $past(rd_stb)); // R9
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !wide_mode) |-> rd_data[31:16] == '0); // R5
    AST_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |=> (rd_valid && !rd_busy && !rd_err && !rd_misalign)); // R7
    AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !rd_busy) |=> rd_valid); // R11
endmodule

// File: tb/regrd_adapter_tb_top.sv
module regrd_adapter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b1;
    logic        rd_stb = 1'b0;
    logic [1:0]  rd_size = 2'd0;
    logic [15:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid, rd_err, rd_misalign, rd_busy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    regrd_adapter dut_i (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .rd_stb(rd_stb),
        .rd_size(rd_size), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_err(rd_err), .rd_misalign(rd_misalign),
        .rd_busy(rd_busy)
    );

    function automatic logic [31:0] pat(input logic [15:0] a);
        logic [13:0] i;
        i = a[15:2];
        return {i[7:0] ^ 8'h5A, 2'b10, i[13:8], ~i[7:0], i[7:0] + 8'h11};
    endfunction

    function automatic logic [7:0] byte_of(input logic [15:0] a);
        logic [31:0] w;
        w = pat(a);
        case (a[1:0])
            2'd0: return w[31:24];
            2'd1: return w[23:16];
            2'd2: return w[15:8];
            default: return w[7:0];
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [31:0] d,
                             input logic v, input logic e, input logic m);
        check(req, rd_data, d);
        check(req, {31'd0, rd_valid}, {31'd0, v});
        check(req, {31'd0, rd_err}, {31'd0, e});
        check(req, {31'd0, rd_misalign}, {31'd0, m});
    endtask

    task automatic issue(input logic [1:0] sz, input logic [15:0] a);
        @(negedge clk);
        rd_stb = 1'b1; rd_size = sz; rd_addr = a;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        rd_stb = 1'b1; rd_size = 2'd2; rd_addr = 16'h0010;
        repeat (3) @(negedge clk);
        check_out("R1", 32'h0, 1'b0, 1'b0, 1'b0);
        rd_stb = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1", 32'h0, 1'b0, 1'b0, 1'b0);
        check("R1", {31'd0, rd_busy}, 32'd0);
    endtask

    task automatic t_narrow_first_after_reset;
        wide_mode = 1'b0;
        issue(2'd1, 16'h0126);
        check_out("R8", {16'h0, pat(16'h0126)[15:0]}, 1'b1, 1'b0, 1'b0);
        issue(2'd0, 16'h0337);
        check_out("R8", {24'h0, byte_of(16'h0337)}, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_wide;
        wide_mode = 1'b1;
        issue(2'd2, 16'h0040);
        check_out("R3", pat(16'h0040), 1'b1, 1'b0, 1'b0);
        issue(2'd2, 16'hFBFC);
        check_out("R2", pat(16'hFBFC), 1'b1, 1'b0, 1'b0);
        issue(2'd1, 16'h0080);
        check_out("R4", {pat(16'h0080)[31:16], 16'h0}, 1'b1, 1'b0, 1'b0);
        issue(2'd1, 16'h0082);
        check_out("R4", {16'h0, pat(16'h0082)[15:0]}, 1'b1, 1'b0, 1'b0);
        for (int n = 0; n < 4; n++) begin
            logic [15:0] a;
            a = 16'h0A10 + 16'(n);
            issue(2'd0, a);
            check_out("R4", 32'(byte_of(a)) << (8 * (3 - n)), 1'b1, 1'b0, 1'b0);
        end
    endtask

    task automatic t_narrow_half_byte;
        wide_mode = 1'b0;
        issue(2'd1, 16'h0200);
        check_out("R5", {16'h0, pat(16'h0200)[31:16]}, 1'b1, 1'b0, 1'b0);
        issue(2'd1, 16'h0202);
        check_out("R5", {16'h0, pat(16'h0202)[15:0]}, 1'b1, 1'b0, 1'b0);
        for (int n = 0; n < 4; n++) begin
            logic [15:0] a;
            a = 16'h1234 + 16'(n);
            issue(2'd0, a);
            check_out("R6", (n % 2 == 1) ? {24'h0, byte_of(a)} : {16'h0, byte_of(a), 8'h0},
                      1'b1, 1'b0, 1'b0);
        end
    endtask

    task automatic t_narrow_word;
        wide_mode = 1'b0;
        @(negedge clk);
        rd_stb = 1'b1; rd_size = 2'd2; rd_addr = 16'h0500;
        @(negedge clk);
        rd_size = 2'd0; rd_addr = 16'h0903;
        check_out("R7", {16'h0, pat(16'h0500)[31:16]}, 1'b1, 1'b0, 1'b0);
        check("R7", {31'd0, rd_busy}, 32'd1);
        @(negedge clk);
        rd_stb = 1'b0;
        check_out("R7", {16'h0, pat(16'h0500)[15:0]}, 1'b1, 1'b0, 1'b0);
        check("R7", {31'd0, rd_busy}, 32'd0);
        @(negedge clk);
        check_out("R7", 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_history;
        wide_mode = 1'b0;
        issue(2'd2, 16'h0600);
        @(negedge clk);
        issue(2'd1, 16'h0702);
        check_out("R8", {16'h0, pat(16'h0702)[15:0]}, 1'b1, 1'b0, 1'b0);
        issue(2'd0, 16'h0801);
        issue(2'd0, 16'h0C03);
        check_out("R8", {24'h0, byte_of(16'h0C03)}, 1'b1, 1'b0, 1'b0);
        issue(2'd0, 16'hFFFF);
        issue(2'd0, 16'h0C02);
        check_out("R8", {16'h0, byte_of(16'h0C02), 8'h0}, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_range;
        wide_mode = 1'b1;
        issue(2'd2, 16'hFC00);
        check_out("R9", 32'h0, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        check_out("R9", 32'h0, 1'b0, 1'b0, 1'b0);
        issue(2'd1, 16'hFC01);
        check_out("R9", 32'h0, 1'b1, 1'b1, 1'b0);
        issue(2'd0, 16'hFBFF);
        check_out("R9", 32'(byte_of(16'hFBFF)), 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_misalign;
        wide_mode = 1'b0;
        issue(2'd1, 16'h0101);
        check_out("R10", 32'h0, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check_out("R10", 32'h0, 1'b0, 1'b0, 1'b0);
        wide_mode = 1'b1;
        issue(2'd2, 16'h0102);
        check_out("R10", 32'h0, 1'b1, 1'b0, 1'b1);
        issue(2'd3, 16'h0100);
        check_out("R10", 32'h0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_back_to_back;
        logic [15:0] a_prev;
        wide_mode = 1'b0;
        a_prev = '0;
        for (int k = 0; k <= 6; k++) begin
            logic [15:0] a;
            a = 16'h2000 + 16'(k * 5);
            @(negedge clk);
            if (k > 0) check_out("R11", {24'h0, byte_of(a_prev)} << (a_prev[0] ? 0 : 8),
                                 1'b1, 1'b0, 1'b0);
            rd_stb = (k < 6); rd_size = 2'd0; rd_addr = a;
            a_prev = a;
        end
        rd_stb = 1'b0;
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_narrow_first_after_reset();
                t_wide();
                t_narrow_half_byte();
                t_narrow_word();
                t_history();
                t_range();
                t_misalign();
                t_back_to_back();
                repeat (2) @(negedge clk);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule